// File: doc/BRIEF.md
# Immediate Opcode Sequencer

This block fetches opcodes from a 64 KiB byte memory and executes the small family of opcodes whose low five bits are all zero. These are break, three inline-offset jumps (conditional, unconditional and subroutine call) and the inline literal pushes. The block owns the 16-bit program counter. It drives push requests toward the stack unit and a pop strobe for the work stack's top byte. Every other opcode goes to an external ALU sequencer, and fetching resumes when that unit reports completion.

The memory port is synchronous. A read issued in one cycle returns its byte in the next cycle, so a 16-bit inline operand costs two read cycles. Jump offsets are added to the address that follows the two operand bytes, and all program counter arithmetic wraps modulo 65536.

The controller is a seven-state machine:
- IDLE waits for a start request.
- FETCH reads the opcode and advances the program counter.
- DECODE classifies the returned opcode.
- OPERAND_A and OPERAND_B issue the operand reads.
- EXEC performs the push and the program counter update.
- ALU_WAIT holds while the external unit runs.

Transitions:
- IDLE goes to FETCH on start.
- FETCH goes to DECODE.
- DECODE goes to IDLE on break, to FETCH on a skipped conditional jump, to ALU_WAIT on a non-immediate opcode, and otherwise to OPERAND_A.
- OPERAND_A goes to EXEC for a byte literal and otherwise to OPERAND_B.
- OPERAND_B goes to EXEC.
- EXEC goes to FETCH.
- ALU_WAIT goes to FETCH once the external unit reports done.

Top module: `imm_seq`

## Requirements
- R1: After reset the block is idle: busy, done, mem_rd, push_valid, pop_req and alu_start are low and pc is 0x0000.
- R2: A start request is refused when start_pc is 0x0000 or stop_flag is high. In that case done is high in the same cycle, no memory read is issued and the block stays idle.
- R3: An opcode with any of its low five bits set raises alu_start for one cycle with alu_opcode equal to that opcode, and no push is made. The block then waits, holding pc, until alu_done and then fetches the next opcode at the address after that opcode.
- R4: Opcode 0x00 (break) raises done in its decode cycle and returns the block to idle. At that point pc holds the break address plus one.
- R5: Opcodes 0x80 and 0xC0 push the next memory byte as an 8-bit value (push_wide=0, push_data[7:0]=byte). push_ret is 0 for 0x80 (work stack) and 1 for 0xC0 (return stack). pc then points past that byte.
- R6: Opcodes 0xA0 and 0xE0 push the next two memory bytes as one 16-bit value, the first byte being the high half (push_wide=1). push_ret is 0 for 0xA0 and 1 for 0xE0. pc then advances past both bytes.
- R7: Opcode 0x40 loads pc with (address after the two operand bytes) + (16-bit operand, high byte first).
- R8: Opcode 0x20 pops the work stack top (pop_req high in decode, byte read from wst_top). If that byte is zero, the two operand bytes are skipped without being read. Otherwise the jump of R7 is taken.
- R9: Opcode 0x60 pushes the address after its two operand bytes as a 16-bit value onto the return stack (push_ret=1, push_wide=1), then jumps as in R7.
- R10: Program counter and operand address arithmetic wrap modulo 65536.
- R11: Cycles from start to the decode of a following break (inclusive of that decode) add up as follows: break 2, byte literal 4, short literal and any taken jump 5, skipped conditional jump 2, and a non-immediate opcode 2 plus its wait cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin execution at start_pc |
| start_pc | input | 16 | Start address |
| stop_flag | input | 1 | Nonzero system stop byte; blocks start |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| wst_top | input | 8 | Current top byte of the work stack |
| pop_req | output | 1 | Pop one byte from the work stack |
| push_valid | output | 1 | Push request |
| push_ret | output | 1 | Push target: 1 return stack, 0 work stack |
| push_wide | output | 1 | Push is 16 bits (1) or 8 bits (0) |
| push_data | output | 16 | Push value (8-bit pushes use bits 7:0) |
| alu_start | output | 1 | Hand a non-immediate opcode to the ALU sequencer |
| alu_opcode | output | 8 | Opcode handed over |
| alu_done | input | 1 | ALU sequencer finished |
| busy | output | 1 | Block is executing |
| done | output | 1 | Break decoded or start refused |
| pc | output | 16 | Program counter |

## Verification
The assertions take three things for granted about the inputs. The memory returns the addressed byte exactly one cycle after each read strobe. wst_top is valid in the decode cycle of a conditional jump. alu_done is raised only after alu_start and while the block waits for it. The bench meets these conditions with a one-cycle registered memory model, a responder that raises alu_done one cycle after it sees alu_start, and start pulses issued only while the block is idle. Stop and zero-address refusals are exercised apart from normal runs.

// File: rtl/imm_pkg.sv
package imm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_OPERAND_A,
        ST_OPERAND_B,
        ST_EXEC,
        ST_ALU_WAIT
    } seq_state_t;

    typedef enum logic [2:0] {
        K_BREAK,
        K_JUMP_COND,
        K_JUMP,
        K_CALL,
        K_LIT_BYTE,
        K_LIT_SHORT,
        K_ALU
    } op_kind_t;

endpackage

// File: rtl/imm_classify.sv
module imm_classify
    import imm_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int SEL_BITS = 5
) (
    input  logic [BYTE_W-1:0] opcode,
    output op_kind_t          kind,
    output logic              to_ret
);
    localparam int TOP = BYTE_W - 1;

    logic [2:0] group;
    assign group  = opcode[TOP -: 3];
    assign to_ret = opcode[TOP-1];

    always_comb begin
        if (opcode[SEL_BITS-1:0] != '0) begin
            kind = K_ALU;
        end else begin
            unique case (group)
                3'b000:  kind = K_BREAK;
                3'b001:  kind = K_JUMP_COND;
                3'b010:  kind = K_JUMP;
                3'b011:  kind = K_CALL;
                3'b100,
                3'b110:  kind = K_LIT_BYTE;
                default: kind = K_LIT_SHORT;
            endcase
        end
    end
endmodule

// File: rtl/imm_operand.sv
module imm_operand #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_high,
    input  logic [BYTE_W-1:0] rdata,
    output logic [WORD_W-1:0] word
);
    logic [BYTE_W-1:0] high_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        high_q <= '0;
        else if (cap_high) high_q <= rdata;
    end

    assign word = {high_q, rdata};
endmodule

// File: rtl/imm_seq.sv
module imm_seq
    import imm_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int SEL_BITS = 5,
    localparam int AW      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_pc,
    input  logic              stop_flag,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [BYTE_W-1:0] wst_top,
    output logic              pop_req,
    output logic              push_valid,
    output logic              push_ret,
    output logic              push_wide,
    output logic [AW-1:0]     push_data,
    output logic              alu_start,
    output logic [BYTE_W-1:0] alu_opcode,
    input  logic              alu_done,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     pc
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    seq_state_t state_q, state_d;
    op_kind_t   kind_q, kind_d, kind_now;
    logic       ret_q, ret_d, ret_now;
    logic [AW-1:0] pc_q, pc_d;
    logic [AW-1:0] operand, after_opnd, target;
    logic       refuse;

    imm_classify #(.BYTE_W(BYTE_W), .SEL_BITS(SEL_BITS)) i_classify (
        .opcode (mem_rdata),
        .kind   (kind_now),
        .to_ret (ret_now)
    );

    imm_operand #(.BYTE_W(BYTE_W)) i_operand (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_high (state_q == ST_OPERAND_B),
        .rdata    (mem_rdata),
        .word     (operand)
    );

    assign refuse     = (start_pc == '0) || stop_flag;
    assign after_opnd = pc_q + TWO;
    assign target     = after_opnd + operand;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_BREAK;
            ret_q   <= 1'b0;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            ret_q   <= ret_d;
            pc_q    <= pc_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        ret_d   = ret_q;
        pc_d    = pc_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && !refuse) begin
                    state_d = ST_FETCH;
                    pc_d    = start_pc;
                end
            end
            ST_FETCH: begin
                state_d = ST_DECODE;
                pc_d    = pc_q + ONE;
            end
            ST_DECODE: begin
                kind_d = kind_now;
                ret_d  = ret_now;
                unique case (kind_now)
                    K_BREAK: state_d = ST_IDLE;
                    K_ALU:   state_d = ST_ALU_WAIT;
                    K_JUMP_COND: begin
                        if (wst_top == '0) begin
                            state_d = ST_FETCH;
                            pc_d    = after_opnd;
                        end else begin
                            state_d = ST_OPERAND_A;
                        end
                    end
                    default: state_d = ST_OPERAND_A;
                endcase
            end
            ST_OPERAND_A: begin
                state_d = (kind_q == K_LIT_BYTE) ? ST_EXEC : ST_OPERAND_B;
            end
            ST_OPERAND_B: state_d = ST_EXEC;
            ST_EXEC: begin
                state_d = ST_FETCH;
                unique case (kind_q)
                    K_LIT_BYTE:  pc_d = pc_q + ONE;
                    K_LIT_SHORT: pc_d = after_opnd;
                    default:     pc_d = target;
                endcase
            end
            ST_ALU_WAIT: begin
                if (alu_done) state_d = ST_FETCH;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd     = (state_q == ST_FETCH) || (state_q == ST_OPERAND_A) ||
                     (state_q == ST_OPERAND_B);
        mem_addr   = (state_q == ST_OPERAND_B) ? pc_q + ONE : pc_q;
        pop_req    = (state_q == ST_DECODE) && (kind_now == K_JUMP_COND);
        alu_start  = (state_q == ST_DECODE) && (kind_now == K_ALU);
        alu_opcode = mem_rdata;
        done       = ((state_q == ST_DECODE) && (kind_now == K_BREAK)) ||
                     ((state_q == ST_IDLE) && start && refuse);
        busy       = (state_q != ST_IDLE);
        push_valid = (state_q == ST_EXEC) &&
                     ((kind_q == K_LIT_BYTE) || (kind_q == K_LIT_SHORT) || (kind_q == K_CALL));
        push_ret   = (kind_q == K_CALL) ? 1'b1 : ret_q;
        push_wide  = (kind_q != K_LIT_BYTE);
        unique case (kind_q)
            K_CALL:      push_data = after_opnd;
            K_LIT_SHORT: push_data = operand;
            default:     push_data = {{(AW-BYTE_W){1'b0}}, mem_rdata};
        endcase
    end

    assign pc = pc_q;

    // assertions
    p_refuse_stays_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && refuse) |=> (state_q == ST_IDLE));

    p_alu_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALU_WAIT && !alu_done) |=> (state_q == ST_ALU_WAIT && $stable(pc_q)));

    p_break_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> !busy);

    p_push_no_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> !mem_rd);

    p_skip_operand_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && wst_top == '0) |=> (state_q == ST_FETCH && pc_q == $past(pc_q) + TWO));

    p_fetch_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE && pc_q == $past(pc_q) + ONE));
endmodule

// File: tb/test_imm_seq.sv
`timescale 1ns/100ps
module test_imm_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_pc = '0;
    logic        stop_flag = 1'b0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  wst_top = '0;
    logic        pop_req, push_valid, push_ret, push_wide;
    logic [15:0] push_data;
    logic        alu_start;
    logic [7:0]  alu_opcode;
    logic        alu_done = 1'b0;
    logic        busy, done;
    logic [15:0] pc;

    int total = 0;
    int bad = 0;

    logic [7:0]  mem [256];
    logic [15:0] pd [8];
    logic        pr [8];
    logic        pw [8];
    int          push_n, pop_n, alu_n;
    logic [7:0]  alu_seen;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

    imm_seq i_imm_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_pc(start_pc),
        .stop_flag(stop_flag), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .wst_top(wst_top), .pop_req(pop_req),
        .push_valid(push_valid), .push_ret(push_ret), .push_wide(push_wide),
        .push_data(push_data), .alu_start(alu_start), .alu_opcode(alu_opcode),
        .alu_done(alu_done), .busy(busy), .done(done), .pc(pc)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic run_prog(input logic [15:0] spc, output int cyc);
        logic pend;
        logic fin;
        pend = 1'b0; fin = 1'b0;
        push_n = 0; pop_n = 0; alu_n = 0; cyc = 0;
        @(negedge clk);
        start_pc = spc; start = 1'b1;
        for (int i = 0; i < 200 && !fin; i++) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            alu_done = pend;
            pend = 1'b0;
            if (push_valid && push_n < 8) begin
                pd[push_n] = push_data; pr[push_n] = push_ret; pw[push_n] = push_wide;
                push_n++;
            end
            if (pop_req) pop_n++;
            if (alu_start) begin alu_n++; alu_seen = alu_opcode; pend = 1'b1; end
            if (done) fin = 1'b1;
        end
        alu_done = 1'b0;
        chk(fin, "run-completes", int'(fin), 1);
    endtask

    task automatic t_reset();
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
        chk(!mem_rd && !push_valid && !pop_req && !alu_start, "R1 strobes",
            {mem_rd, push_valid, pop_req, alu_start}, 0);
        chk(pc == 16'h0000, "R1 pc", pc, 0);
    endtask

    task automatic t_refuse();
        @(negedge clk);
        start_pc = 16'h0000; start = 1'b1;
        #1;
        chk(done && !mem_rd, "R2 zero start done", {done, mem_rd}, 2);
        @(negedge clk);
        start = 1'b0;
        chk(!busy, "R2 zero start idle", busy, 0);
        start_pc = 16'h0100; stop_flag = 1'b1; start = 1'b1;
        #1;
        chk(done && !mem_rd, "R2 stop flag done", {done, mem_rd}, 2);
        @(negedge clk);
        start = 1'b0; stop_flag = 1'b0;
        chk(!busy && pc == 16'h0000, "R2 stop flag idle", {busy, pc}, 0);
    endtask

    task automatic t_break();
        int c;
        clear_mem();
        run_prog(16'h0100, c);
        chk(c == 2, "R4 R11 break cycles", c, 2);
        chk(pc == 16'h0101, "R4 pc after break", pc, 16'h0101);
        @(negedge clk);
        chk(!busy, "R4 idle after break", busy, 0);
    endtask

    task automatic t_lit_byte();
        int c;
        clear_mem();
        mem[8'h00] = 8'h80; mem[8'h01] = 8'hA5;
        mem[8'h02] = 8'hC0; mem[8'h03] = 8'h3C;
        run_prog(16'h0100, c);
        chk(c == 10, "R5 R11 byte literal cycles", c, 10);
        chk(push_n == 2, "R5 push count", push_n, 2);
        chk(pd[0][7:0] == 8'hA5 && !pr[0] && !pw[0], "R5 work byte push",
            {pr[0], pw[0], pd[0][7:0]}, 8'hA5);
        chk(pd[1][7:0] == 8'h3C && pr[1] && !pw[1], "R5 return byte push",
            {pr[1], pw[1], pd[1][7:0]}, 10'h23C);
        chk(pc == 16'h0105, "R5 pc", pc, 16'h0105);
    endtask

    task automatic t_lit_short();
        int c;
        clear_mem();
        mem[8'h00] = 8'hA0; mem[8'h01] = 8'h12; mem[8'h02] = 8'h34;
        mem[8'h03] = 8'hE0; mem[8'h04] = 8'hBE; mem[8'h05] = 8'hEF;
        run_prog(16'h0100, c);
        chk(c == 12, "R6 R11 short literal cycles", c, 12);
        chk(push_n == 2 && pd[0] == 16'h1234 && !pr[0] && pw[0], "R6 work short push",
            pd[0], 16'h1234);
        chk(pd[1] == 16'hBEEF && pr[1] && pw[1], "R6 return short push", pd[1], 16'hBEEF);
        chk(pc == 16'h0107, "R6 pc", pc, 16'h0107);
    endtask

    task automatic t_jump();
        int c;
        clear_mem();
        mem[8'h00] = 8'h40; mem[8'h01] = 8'h00; mem[8'h02] = 8'h10;
        mem[8'h13] = 8'h00;
        run_prog(16'h0100, c);
        chk(c == 7, "R7 R11 jump cycles", c, 7);
        chk(pc == 16'h0114, "R7 forward jump", pc, 16'h0114);
        clear_mem();
        mem[8'h00] = 8'h40; mem[8'h01] = 8'hFF; mem[8'h02] = 8'hF0;
        run_prog(16'h0200, c);
        chk(pc == 16'h01F4, "R7 backward jump", pc, 16'h01F4);
        chk(push_n == 0 && pop_n == 0, "R7 no stack traffic", push_n + pop_n, 0);
    endtask

    task automatic t_cond();
        int c;
        clear_mem();
        mem[8'h00] = 8'h20; mem[8'h01] = 8'h00; mem[8'h02] = 8'h10;
        wst_top = 8'h00;
        run_prog(16'h0100, c);
        chk(c == 4, "R8 R11 skipped cycles", c, 4);
        chk(pc == 16'h0104 && pop_n == 1, "R8 zero skips operand", pc, 16'h0104);
        wst_top = 8'h05;
        run_prog(16'h0100, c);
        chk(c == 7, "R8 taken cycles", c, 7);
        chk(pc == 16'h0114 && pop_n == 1, "R8 nonzero jumps", pc, 16'h0114);
        wst_top = 8'h00;
    endtask

    task automatic t_call();
        int c;
        clear_mem();
        mem[8'h00] = 8'h60; mem[8'h01] = 8'h00; mem[8'h02] = 8'h20;
        run_prog(16'h0100, c);
        chk(push_n == 1 && pd[0] == 16'h0103, "R9 return address", pd[0], 16'h0103);
        chk(pr[0] && pw[0], "R9 return stack wide", {pr[0], pw[0]}, 3);
        chk(pc == 16'h0124, "R9 call target", pc, 16'h0124);
    endtask

    task automatic t_wrap();
        int c;
        clear_mem();
        mem[8'hF0] = 8'h40; mem[8'hF1] = 8'h00; mem[8'hF2] = 8'h20;
        run_prog(16'hFFF0, c);
        chk(pc == 16'h0014, "R10 jump wraps", pc, 16'h0014);
        clear_mem();
        mem[8'hFE] = 8'hA0; mem[8'hFF] = 8'h5A; mem[8'h00] = 8'h6B;
        run_prog(16'hFFFE, c);
        chk(push_n == 1 && pd[0] == 16'h5A6B, "R10 operand read wraps", pd[0], 16'h5A6B);
        chk(pc == 16'h0002, "R10 pc wraps", pc, 16'h0002);
    endtask

    task automatic t_alu();
        int c;
        clear_mem();
        mem[8'h00] = 8'h01;
        run_prog(16'h0100, c);
        chk(alu_n == 1 && alu_seen == 8'h01, "R3 handoff opcode", alu_seen, 8'h01);
        chk(push_n == 0, "R3 no push", push_n, 0);
        chk(c == 5, "R3 R11 handoff cycles", c, 5);
        chk(pc == 16'h0102, "R3 resume address", pc, 16'h0102);
    endtask

    initial begin
        #100000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refuse();
        t_break();
        t_lit_byte();
        t_lit_short();
        t_jump();
        t_cond();
        t_call();
        t_wrap();
        t_alu();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule